// File: doc/BRIEF.md
# Bit-Level Correlation Matrix Recall Array

This block is a binary associative memory in which every weight bit sits inside its own small processing cell together with an adder. The cells form a grid of `ROWS` rows (one per output neuron) by `COLS` columns (one per input pattern bit). Each input pattern bit is broadcast down its column and acts as the selector for every stored bit in that column. Each row builds its count from left to right. A cell passes the partial sum from its left neighbour through unchanged, or adds its stored bit to it when its column is active. The right edge of every row therefore carries the number of positions where both the pattern and the stored row hold a one.

A recall is requested by pulsing `start` with the pattern present. All row counts are formed in parallel by the combinational cell chain and captured into an output register on that same edge. `out_valid` marks them in the following cycle. Weights are loaded one bit at a time through a row/column address with write data and a write enable. Thresholding of the counts and the policy for training the weights belong to the logic around this block.

Top module: `cmm_recall_array`

## Requirements
- R1: After reset, `out_valid` is 0, `sums` is all zeros and every stored weight is 0, so a recall of any pattern returns 0 on every row.
- R2: A write with `wr_en`=1, `wr_row`=r (0..ROWS-1) and `wr_col`=c (0..COLS-1) stores `wr_data` into the single cell (r,c) at the next clock edge and leaves every other cell unchanged.
- R3: A write whose `wr_row` is ROWS or more, or whose `wr_col` is COLS or more, changes no stored weight.
- R4: When `start` is 1 at a clock edge, each row r's count is the number of columns j where `pattern[j]`=1 and weight (r,j)=1, using the pattern present at that edge.
- R5: `out_valid` is 1 in exactly the cycle after each clock edge at which `start` was 1 and is 0 otherwise. Starts on consecutive cycles give results on consecutive cycles.
- R6: While `start` is 0, `sums` holds the last recall result regardless of `pattern` and writes.
- R7: When `start` and `wr_en` are both 1 at the same edge, the recall uses the weights as they were before that write, and the write applies to later recalls.
- R8: An all-zero pattern gives 0 on every row, and a row of all ones recalled with an all-ones pattern gives exactly COLS with no wrap-around.
- R9: Row r's count occupies `sums[r*SW +: SW]`, where SW = clog2(COLS+1), unsigned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Weight write enable |
| wr_row | input | clog2(ROWS) | Row address of the weight bit to write |
| wr_col | input | clog2(COLS) | Column address of the weight bit to write |
| wr_data | input | 1 | Weight value to store |
| start | input | 1 | Recall request, one cycle per recall |
| pattern | input | COLS | Binary input pattern, bit j drives column j |
| out_valid | output | 1 | Row counts valid this cycle |
| sums | output | ROWS*SW | Packed per-row counts, row r at bits r*SW upward |

## Verification
A weight write and a recall can land on the same clock edge, and the block must then count with the old weight while still storing the new one. The bench provokes this by issuing a recall with an all-ones pattern while flipping a cell that the pattern selects. It then issues a second recall with no write. The scoreboard predicts the first result from the model before the write and the second from the model after it, so a design that lets the write leak into the same-cycle count, or drops the write, fails one of the two comparisons.

// File: rtl/cmm_pkg.sv
package cmm_pkg;

  // Bits needed by the partial sum leaving column k (0..k+1 ones).
  function automatic int stage_width(input int k);
    return $clog2(k + 2);
  endfunction

  // Bit offset of column k's partial sum inside a row's packed chain.
  function automatic int stage_offset(input int k);
    int acc;
    acc = 0;
    for (int i = 0; i < k; i++) acc += stage_width(i);
    return acc;
  endfunction

  // Width of a full row count.
  function automatic int count_width(input int cols);
    return $clog2(cols + 1);
  endfunction

  // Address width for an index space of n entries.
  function automatic int addr_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/cmm_addr_dec.sv
module cmm_addr_dec #(
  parameter int N  = 4,
  parameter int AW = 2
) (
  input  logic          en,
  input  logic [AW-1:0] addr,
  output logic [N-1:0]  hit
);
  // One-hot decode; an address at or beyond N selects nothing.
  for (genvar i = 0; i < N; i++) begin : g_dec
    assign hit[i] = en && (addr == AW'(i));
  end
endmodule

// File: rtl/cmm_cell.sv
module cmm_cell
  import cmm_pkg::*;
#(
  parameter int IDX = 0,
  parameter int IW  = (IDX == 0) ? 1 : stage_width(IDX - 1),
  parameter int OW  = stage_width(IDX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          wd,
  input  logic          sel,
  input  logic [IW-1:0] sum_in,
  output logic [OW-1:0] sum_out
);
  logic          w_q;
  logic [OW-1:0] pass_val;
  logic [OW-1:0] bump_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  w_q <= 1'b0;
    else if (we) w_q <= wd;
  end

  // Column bit selects between pass-through and pass-plus-stored-bit.
  always_comb begin
    pass_val = OW'(sum_in);
    bump_val = pass_val + OW'(w_q);
    sum_out  = sel ? bump_val : pass_val;
  end
endmodule

// File: rtl/cmm_row.sv
module cmm_row
  import cmm_pkg::*;
#(
  parameter int COLS = 10,
  localparam int SW  = count_width(COLS),
  localparam int TOT = stage_offset(COLS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            row_we,
  input  logic [COLS-1:0] col_hit,
  input  logic            wd,
  input  logic [COLS-1:0] pattern,
  output logic [SW-1:0]   row_sum,
  output logic [COLS-1:0] cell_we
);
  // Partial sums of all columns, each at its own width, packed end to end.
  logic [TOT-1:0] chain;

  for (genvar k = 0; k < COLS; k++) begin : g_col
    localparam int OW  = stage_width(k);
    localparam int OFS = stage_offset(k);
    assign cell_we[k] = row_we & col_hit[k];
    if (k == 0) begin : g_first
      cmm_cell #(.IDX(0)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cell_we[k]),
        .wd     (wd),
        .sel    (pattern[k]),
        .sum_in (1'b0),
        .sum_out(chain[OFS +: OW])
      );
    end else begin : g_next
      localparam int IW   = stage_width(k - 1);
      localparam int IOFS = stage_offset(k - 1);
      cmm_cell #(.IDX(k)) u_cell (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cell_we[k]),
        .wd     (wd),
        .sel    (pattern[k]),
        .sum_in (chain[IOFS +: IW]),
        .sum_out(chain[OFS +: OW])
      );
    end
  end

  assign row_sum = chain[stage_offset(COLS - 1) +: SW];
endmodule

// File: rtl/cmm_recall_array.sv
module cmm_recall_array
  import cmm_pkg::*;
#(
  parameter int ROWS = 6,
  parameter int COLS = 10,
  localparam int SW  = count_width(COLS),
  localparam int RAW = addr_width(ROWS),
  localparam int CAW = addr_width(COLS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [RAW-1:0]     wr_row,
  input  logic [CAW-1:0]     wr_col,
  input  logic               wr_data,
  input  logic               start,
  input  logic [COLS-1:0]    pattern,
  output logic               out_valid,
  output logic [ROWS*SW-1:0] sums
);
  // Named internal events, brought out for the checker.
  logic [ROWS-1:0]      row_hit;
  logic [COLS-1:0]      col_hit;
  logic [ROWS*COLS-1:0] cell_we_flat;
  logic [ROWS*SW-1:0]   edge_sums;
  logic                 rec_fire;

  assign rec_fire = start;

  cmm_addr_dec #(.N(ROWS), .AW(RAW)) u_row_dec (
    .en(wr_en), .addr(wr_row), .hit(row_hit)
  );
  cmm_addr_dec #(.N(COLS), .AW(CAW)) u_col_dec (
    .en(1'b1), .addr(wr_col), .hit(col_hit)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    cmm_row #(.COLS(COLS)) u_row (
      .clk    (clk),
      .rst_n  (rst_n),
      .row_we (row_hit[r]),
      .col_hit(col_hit),
      .wd     (wr_data),
      .pattern(pattern),
      .row_sum(edge_sums[r*SW +: SW]),
      .cell_we(cell_we_flat[r*COLS +: COLS])
    );
  end

  // Right-edge capture: counts from pre-edge weights, valid one cycle on.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      sums      <= '0;
    end else begin
      out_valid <= rec_fire;
      if (rec_fire) sums <= edge_sums;
    end
  end
endmodule

// File: rtl/cmm_recall_checker.sv
module cmm_recall_checker #(
  parameter int ROWS = 6,
  parameter int COLS = 10,
  localparam int SW  = $clog2(COLS + 1)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [COLS-1:0]    pattern,
  input logic               out_valid,
  input logic [ROWS*SW-1:0] sums,
  input logic [ROWS*COLS-1:0] cell_we
);
  // R5: a recall request yields a valid result on the next cycle.
  assert_valid_after_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> out_valid);

  // R5: no valid result without a request.
  assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> !out_valid);

  // R6: counts hold while no recall is requested.
  assert_hold_when_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> $stable(sums));

  // R2: a write touches at most one cell.
  assert_single_cell_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cell_we));

  for (genvar r = 0; r < ROWS; r++) begin : g_row_chk
    // R4: a row count cannot exceed the active pattern bits.
    assert_count_bounded_R4: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (sums[r*SW +: SW] <= SW'($countones($past(pattern)))));
    // R8: counts never exceed the column count.
    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (sums[r*SW +: SW] <= SW'(COLS)));
  end
endmodule

bind cmm_recall_array cmm_recall_checker #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .pattern  (pattern),
  .out_valid(out_valid),
  .sums     (sums),
  .cell_we  (cell_we_flat)
);

// File: tb/cmm_recall_array_tb.sv
module cmm_recall_array_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS = 6;
  localparam int COLS = 10;
  localparam int SW   = 4;
  localparam int RAW  = 3;
  localparam int CAW  = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0;
  logic [RAW-1:0]     wr_row = '0;
  logic [CAW-1:0]     wr_col = '0;
  logic               wr_data = 1'b0;
  logic               start = 1'b0;
  logic [COLS-1:0]    pattern = '0;
  logic               out_valid;
  logic [ROWS*SW-1:0] sums;

  int  errors = 0;
  int  checks = 0;
  bit  done = 1'b0;
  bit  wm [ROWS][COLS];
  logic [ROWS*SW-1:0] exp_q [$];
  string              tag_q [$];
  logic [ROWS*SW-1:0] last_exp = '0;
  logic               start_seen = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmm_recall_array #(.ROWS(ROWS), .COLS(COLS)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_col(wr_col),
    .wr_data(wr_data), .start(start), .pattern(pattern),
    .out_valid(out_valid), .sums(sums)
  );

  // Independent count: row r at field r*SW (R9).
  function automatic logic [ROWS*SW-1:0] predict(input logic [COLS-1:0] p);
    logic [ROWS*SW-1:0] v;
    v = '0;
    for (int r = 0; r < ROWS; r++) begin
      int n;
      n = 0;
      for (int c = 0; c < COLS; c++) if (p[c] && wm[r][c]) n++;
      v[r*SW +: SW] = SW'(n);
    end
    return v;
  endfunction

  task automatic wr_cell(input int r, input int c, input bit d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_row = RAW'(r); wr_col = CAW'(c); wr_data = d;
    if (r < ROWS && c < COLS) wm[r][c] = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // Driver: requests a recall and pushes its expected counts.
  task automatic recall(input logic [COLS-1:0] p, input string tag,
                        input bit do_wr = 1'b0, input int r = 0, input int c = 0,
                        input bit d = 1'b0);
    @(posedge clk); #1;
    start = 1'b1; pattern = p;
    exp_q.push_back(predict(p));
    tag_q.push_back(tag);
    if (do_wr) begin
      wr_en = 1'b1; wr_row = RAW'(r); wr_col = CAW'(c); wr_data = d;
      if (r < ROWS && c < COLS) wm[r][c] = d;
    end else begin
      wr_en = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    @(posedge clk); #1;
    start = 1'b0; wr_en = 1'b0;
    for (int i = 1; i < n; i++) @(posedge clk);
    #1;
  endtask

  always @(posedge clk) start_seen <= rst_n ? start : 1'b0;

  // Monitor: valid timing (R5) and scoreboard comparison (R9 field layout).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (out_valid !== start_seen) begin
        errors++;
        $display("FAIL R5 out_valid actual=%0b expected=%0b", out_valid, start_seen);
      end
      if (out_valid === 1'b1) begin
        if (exp_q.size() == 0) begin
          errors++; checks++;
          $display("FAIL R5 result with no pending recall actual=1 expected=0");
        end else begin
          logic [ROWS*SW-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          last_exp = e;
          for (int r = 0; r < ROWS; r++) begin
            checks++;
            if (sums[r*SW +: SW] !== e[r*SW +: SW]) begin
              errors++;
              $display("FAIL %s (R9 field) row %0d actual=%0d expected=%0d",
                       t, r, sums[r*SW +: SW], e[r*SW +: SW]);
            end
          end
        end
      end
    end
  end

  task automatic check_hold(input string tag);
    @(negedge clk);
    checks++;
    if (sums !== last_exp) begin
      errors++;
      $display("FAIL %s held sums actual=%h expected=%h", tag, sums, last_exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++) wm[r][c] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state at the ports.
    checks++;
    if (out_valid !== 1'b0 || sums !== '0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%h expected=0/0", out_valid, sums);
    end
    @(posedge clk); #1 rst_n = 1'b1;

    // R1: weights cleared, so an all-ones recall counts zero.
    recall('1, "R1");
    idle(2);

    // R2: load a mixed weight pattern cell by cell.
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c < COLS; c++)
        wr_cell(r, c, bit'(((r * 3 + c * 7) % 5) < 2));

    // R4: several distinct patterns.
    recall('1, "R4");
    recall(10'b1010101010, "R4");
    recall(10'b0000000001, "R4");
    recall(10'b1100110011, "R4");
    idle(2);
    // R8: all-zero pattern.
    recall('0, "R8");
    idle(2);

    // R8: a full row recalled with all ones reaches COLS.
    for (int c = 0; c < COLS; c++) wr_cell(0, c, 1'b1);
    recall('1, "R8");
    idle(2);

    // R3: out-of-range rows and columns leave weights alone.
    wr_cell(6, 2, 1'b0);
    wr_cell(7, 0, 1'b0);
    wr_cell(2, 10, 1'b1);
    wr_cell(2, 15, 1'b1);
    recall('1, "R3");
    idle(2);

    // R2: a single in-range write changes one cell.
    wr_cell(3, 4, ~wm[3][4]);
    recall('1, "R2");
    idle(2);

    // R7: same-edge write and recall: old weight counted, new weight kept.
    recall('1, "R7", 1'b1, 0, 0, 1'b0);
    idle(2);
    recall('1, "R7");
    idle(2);

    // R5: back-to-back recalls.
    recall(10'b0111100000, "R5");
    recall(10'b0000011111, "R5");
    recall(10'b1000000001, "R5");
    idle(3);

    // R6: hold while idle, with pattern and a write moving underneath.
    check_hold("R6");
    pattern = 10'b1111100000;
    check_hold("R6");
    wr_cell(5, 9, ~wm[5][9]);
    pattern = 10'b0101010101;
    check_hold("R6");

    idle(3);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R5 pending results actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule